// File: doc/BRIEF.md
# Three-Wire Real-Time-Clock Serial Master

This block drives a three-wire serial link to a real-time-clock device: an active-high enable strobe, a serial clock and a single data line that both ends take turns driving. A host inside the chip asks for one register access at a time. It gives a 5-bit register index, a direction and, for writes, one data byte. The block then runs the whole bus exchange without further help from the host.

Each transaction opens with the clock low and the enable strobe raised. It carries a command byte and then a data byte, both least significant bit first, and closes by dropping the strobe while the clock is low. On a read the master lets go of the data line after the command byte and shifts in the answer. Every register write goes out as three transactions: write protect off, the register write itself, write protect back on.

A build-time read-only option refuses every register write except those to the trickle-charge register (index 8). The serial clock half-period comes from a divider set by the system clock rate in MHz and a minimum half-period in microseconds.

Top module: `rtc3w_master`

## Requirements
- R1: After reset and whenever no transaction is in progress, enable, serial clock, busy and done are low and the data line is released (output enable 0).
- R2: The enable strobe rises and falls only while the serial clock is low, and each transaction has exactly 16 rising clock edges.
- R3: Outgoing bytes are sent least significant bit first. The data output changes only while the serial clock is low, so the device can latch it on the rising edge.
- R4: The command byte is 0x81 | (index << 1) for a read and 0x80 | (index << 1) for a write.
- R5: A write produces three transactions in this order: command 0x8E with data 0x00, then the register write, then command 0x8E with data 0x80.
- R6: On a read, output enable is 0 for the whole response byte. The byte is sampled least significant bit first, near the end of each clock-low half, and is presented on rd_data.
- R7: Every serial clock half-period lasts at least CLK_MHZ*HALF_US system clock cycles.
- R8: req_start is taken only while busy is low. busy is high from the cycle after an accepted start until done. done is a one-cycle pulse. rd_data stays unchanged from done until the next read finishes.
- R9: With READ_ONLY=1, a write to any index other than 8 gives a done pulse with no bus activity (enable never rises). A write to index 8 runs the normal three-transaction sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Request strobe, taken while busy is low |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_index | input | 5 | Register index |
| req_wdata | input | 8 | Data byte for a write |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte returned by the last read |
| ce_o | output | 1 | Transaction enable strobe to the device |
| sclk_o | output | 1 | Serial clock to the device |
| sdio_o | output | 1 | Data line output value |
| sdio_oe | output | 1 | Data line drive enable (1 = master drives) |
| sdio_i | input | 1 | Data line value seen at the pin |

## Verification
The assertions assume a device that changes the data line only after a falling serial clock edge and only during the response byte of a read. They also assume the host holds the request fields steady for the cycle in which req_start is taken. The bench device model drives the line only in that window. The bench driver sets the request fields in the same cycle as the strobe and drops the strobe one cycle later. A start issued while busy is high is expected to leave the bus traffic and the result unchanged.

// File: rtl/rtc3w_pkg.sv
package rtc3w_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ARM,
        PH_OPEN,
        PH_LOW,
        PH_HIGH,
        PH_TAIL,
        PH_CLOSE
    } phase_e;

    typedef struct packed {
        logic       wr;
        logic [4:0] idx;
        logic [7:0] data;
    } req_t;

    localparam logic [7:0] PROT_CMD   = 8'h8E;
    localparam logic [7:0] PROT_OFF   = 8'h00;
    localparam logic [7:0] PROT_ON    = 8'h80;

    // bit7 fixed 1, bit6 0, index in bits 5..1, bit0 = read
    function automatic logic [7:0] cmd_byte(input logic rd, input logic [4:0] idx);
        return {1'b1, 1'b0, idx, rd};
    endfunction

    // frame word = {data, command}; shifted out from bit 0 upward
    function automatic logic [15:0] frame_word(input req_t r, input logic [1:0] seg);
        logic [15:0] f;
        if (!r.wr)
            f = {8'h00, cmd_byte(1'b1, r.idx)};
        else if (seg == 2'd0)
            f = {PROT_OFF, PROT_CMD};
        else if (seg == 2'd1)
            f = {r.data, cmd_byte(1'b0, r.idx)};
        else
            f = {PROT_ON, PROT_CMD};
        return f;
    endfunction

endpackage

// File: rtl/rtc3w_tick.sv
module rtc3w_tick #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rtc3w_frame.sv
module rtc3w_frame
    import rtc3w_pkg::*;
(
    input  req_t        op,
    input  logic [1:0]  seg,
    output logic [15:0] frame
);
    always_comb frame = frame_word(op, seg);
endmodule

// File: rtl/rtc3w_rx.sv
module rtc3w_rx (
    input  logic       clk,
    input  logic       rst,
    input  logic       sample,
    input  logic       bit_in,
    output logic [7:0] byte_out
);
    always_ff @(posedge clk) begin
        if (rst)
            byte_out <= '0;
        else if (sample)
            byte_out <= {bit_in, byte_out[7:1]};
    end
endmodule

// File: rtl/rtc3w_master.sv
module rtc3w_master
    import rtc3w_pkg::*;
#(
    parameter int         CLK_MHZ     = 100,
    parameter int         HALF_US     = 1,
    parameter bit         READ_ONLY   = 1'b0,
    parameter logic [4:0] TRICKLE_IDX = 5'd8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_start,
    input  logic       req_write,
    input  logic [4:0] req_index,
    input  logic [7:0] req_wdata,
    output logic       busy,
    output logic       done,
    output logic [7:0] rd_data,
    output logic       ce_o,
    output logic       sclk_o,
    output logic       sdio_o,
    output logic       sdio_oe,
    input  logic       sdio_i
);
    localparam int DIV = CLK_MHZ * HALF_US;

    phase_e      ph;
    req_t        op;
    logic [1:0]  seg;
    logic [3:0]  bitn;
    logic [15:0] tx;
    logic [15:0] frame;
    logic [7:0]  rx_byte;
    logic [7:0]  rd_q;
    logic        done_q;
    logic        tick;
    logic        blocked;
    logic        rx_phase;
    logic [1:0]  last_seg;

    assign blocked  = READ_ONLY && req_write && (req_index != TRICKLE_IDX);
    assign last_seg = op.wr ? 2'd2 : 2'd0;
    assign rx_phase = (ph == PH_LOW || ph == PH_HIGH) && bitn[3] && !op.wr;

    rtc3w_tick #(.DIV(DIV)) u_tick (
        .clk (clk),
        .rst (rst),
        .run (ph != PH_IDLE),
        .tick(tick)
    );

    rtc3w_frame u_frame (
        .op   (op),
        .seg  (seg),
        .frame(frame)
    );

    rtc3w_rx u_rx (
        .clk     (clk),
        .rst     (rst),
        .sample  (tick && ph == PH_LOW && rx_phase),
        .bit_in  (sdio_i),
        .byte_out(rx_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_IDLE;
            op     <= '0;
            seg    <= '0;
            bitn   <= '0;
            tx     <= '0;
            rd_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (ph)
                PH_IDLE: if (req_start) begin
                    if (blocked) begin
                        done_q <= 1'b1;
                    end else begin
                        op  <= '{wr: req_write, idx: req_index, data: req_wdata};
                        seg <= 2'd0;
                        ph  <= PH_ARM;
                    end
                end
                PH_ARM: if (tick) begin
                    tx   <= frame;
                    bitn <= '0;
                    ph   <= PH_OPEN;
                end
                PH_OPEN: if (tick) ph <= PH_LOW;
                PH_LOW:  if (tick) ph <= PH_HIGH;
                PH_HIGH: if (tick) begin
                    if (bitn == 4'd15) begin
                        ph <= PH_TAIL;
                    end else begin
                        bitn <= bitn + 4'd1;
                        tx   <= {1'b0, tx[15:1]};
                        ph   <= PH_LOW;
                    end
                end
                PH_TAIL: if (tick) ph <= PH_CLOSE;
                PH_CLOSE: if (tick) begin
                    if (seg == last_seg) begin
                        ph     <= PH_IDLE;
                        done_q <= 1'b1;
                        if (!op.wr) rd_q <= rx_byte;
                    end else begin
                        seg <= seg + 2'd1;
                        ph  <= PH_ARM;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign busy    = (ph != PH_IDLE);
    assign done    = done_q;
    assign rd_data = rd_q;
    assign ce_o    = (ph == PH_OPEN) || (ph == PH_LOW) || (ph == PH_HIGH) || (ph == PH_TAIL);
    assign sclk_o  = (ph == PH_HIGH);
    assign sdio_oe = (ph == PH_LOW || ph == PH_HIGH) && (!bitn[3] || op.wr);
    assign sdio_o  = sdio_oe ? tx[0] : 1'b0;

    // ---------------- assertions ----------------
    logic sclk_q;
    int   hp_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            hp_cnt <= DIV;
        end else begin
            sclk_q <= sclk_o;
            if (sclk_o != sclk_q) begin
                assert_half_period_R7: assert (hp_cnt >= DIV)
                    else $error("serial clock half-period too short: %0d", hp_cnt);
                hp_cnt <= 1;
            end else if (hp_cnt < DIV) begin
                hp_cnt <= hp_cnt + 1;
            end
        end
    end

    assert_released_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !ce_o |-> !sdio_oe);

    assert_ce_edge_clock_low_R2: assert property (@(posedge clk) disable iff (rst)
        ($rose(ce_o) || $fell(ce_o)) |-> !sclk_o);

    assert_data_stable_high_R3: assert property (@(posedge clk) disable iff (rst)
        (sclk_o && $past(sclk_o)) |-> $stable(sdio_o));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_busy_after_start_R8: assert property (@(posedge clk) disable iff (rst)
        (req_start && !busy && !blocked) |=> busy);

    assert_blocked_write_R9: assert property (@(posedge clk) disable iff (rst)
        (req_start && !busy && blocked) |=> (done && !busy && !ce_o));

endmodule

// File: tb/rtc3w_master_tb.sv
module rtc3w_master_tb;
    localparam int MHZ = 4;
    localparam int HUS = 1;
    localparam int DIV = MHZ * HUS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic       req_start = 1'b0, req_write = 1'b0;
    logic [4:0] req_index = '0;
    logic [7:0] req_wdata = '0;
    logic       busy, done, ce, sclk, sdo, oe;
    logic       sdi = 1'b0;
    logic [7:0] rd_data;

    rtc3w_master #(.CLK_MHZ(MHZ), .HALF_US(HUS)) u_dut (
        .clk(clk), .rst(rst), .req_start(req_start), .req_write(req_write),
        .req_index(req_index), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .ce_o(ce), .sclk_o(sclk), .sdio_o(sdo),
        .sdio_oe(oe), .sdio_i(sdi)
    );

    logic       ro_start = 1'b0, ro_write = 1'b0;
    logic [4:0] ro_index = '0;
    logic       ro_busy, ro_done, ro_ce, ro_sclk, ro_sdo, ro_oe;
    logic [7:0] ro_rd;

    rtc3w_master #(.CLK_MHZ(MHZ), .HALF_US(HUS), .READ_ONLY(1'b1)) u_ro (
        .clk(clk), .rst(rst), .req_start(ro_start), .req_write(ro_write),
        .req_index(ro_index), .req_wdata(8'h3C), .busy(ro_busy), .done(ro_done),
        .rd_data(ro_rd), .ce_o(ro_ce), .sclk_o(ro_sclk), .sdio_o(ro_sdo),
        .sdio_oe(ro_oe), .sdio_i(1'b0)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- device model and scoreboard ----------------
    logic [15:0] exp_q[$];
    logic [7:0]  dev_mem[32];
    logic [7:0]  exp_mem[32];
    int          bcnt;
    logic [7:0]  dcmd, ddat;
    bit          dwp = 1'b1;
    bit          oe_bad;
    int          ro_ce_rises = 0;

    initial begin
        for (int i = 0; i < 32; i++) begin
            dev_mem[i] = 8'(i * 29) ^ 8'h6B;
            exp_mem[i] = 8'(i * 29) ^ 8'h6B;
        end
    end

    always @(posedge ro_ce) ro_ce_rises++;

    always @(posedge ce) begin
        bcnt = 0; dcmd = '0; ddat = '0; oe_bad = 1'b0;
    end

    always @(posedge sclk) if (ce) begin
        if (bcnt < 8) dcmd[bcnt] = sdo;
        else if (bcnt < 16 && !dcmd[0]) ddat[bcnt-8] = sdo;
        if (bcnt >= 8 && dcmd[0] && oe) oe_bad = 1'b1;
        bcnt++;
    end

    always @(negedge sclk) if (ce && dcmd[0] && bcnt >= 8 && bcnt < 16) begin
        sdi = dev_mem[dcmd[5:1]][bcnt-8];
        ddat[bcnt-8] = sdi;
    end

    always @(negedge ce) begin
        logic [15:0] e;
        sdi = 1'b0;
        chk(bcnt == 16, "R2", "rising clock edges per transaction", bcnt, 16);
        chk(!oe_bad, "R6", "line released during response", oe_bad, 0);
        chk(exp_q.size() > 0, "R8", "unexpected extra transaction", {ddat, dcmd}, 0);
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            chk({ddat, dcmd} == e, "R4", "transaction {data,cmd}", {ddat, dcmd}, e);
        end
        if (!dcmd[0]) begin
            if (dcmd[5:1] == 5'd7) dwp = ddat[7];
            else if (!dwp) dev_mem[dcmd[5:1]] = ddat;
        end
    end

    // clock half-period monitor
    int min_half = 1000000;
    int run_len  = 0;
    logic sclk_prev = 1'b0;
    always @(negedge clk) begin
        if (sclk !== sclk_prev) begin
            if (run_len < min_half) min_half = run_len;
            run_len = 1;
        end else begin
            run_len++;
        end
        sclk_prev = sclk;
    end

    // ---------------- driver ----------------
    task automatic do_op(input bit wr, input logic [4:0] idx, input logic [7:0] d,
                         input bit poke);
        logic [7:0] c;
        int n;
        c = {1'b1, 1'b0, idx, !wr};
        if (wr) begin
            exp_q.push_back({8'h00, 8'h8E});   // R5 protect off
            exp_q.push_back({d, c});
            exp_q.push_back({8'h80, 8'h8E});   // R5 protect on
            exp_mem[idx] = d;
        end else begin
            exp_q.push_back({exp_mem[idx], c});
        end
        @(negedge clk);
        while (busy) @(negedge clk);
        req_start = 1'b1; req_write = wr; req_index = idx; req_wdata = d;
        @(negedge clk);
        req_start = 1'b0;
        chk(busy == 1'b1, "R8", "busy after start", busy, 1);
        if (poke) begin
            repeat (40) @(negedge clk);
            req_start = 1'b1; req_write = 1'b1; req_index = 5'd2; req_wdata = 8'h11;
            @(negedge clk);
            req_start = 1'b0;
        end
        n = 0;
        while (!done && n < 5000) begin @(negedge clk); n++; end
        chk(done == 1'b1, "R8", "done reached", done, 1);
        chk(busy == 1'b0, "R8", "busy low at done", busy, 0);
        if (!wr) chk(rd_data == exp_mem[idx], "R6", "read data", rd_data, exp_mem[idx]);
        chk(exp_q.size() == 0, "R5", "transactions outstanding", exp_q.size(), 0);
        @(negedge clk);
        chk(done == 1'b0, "R8", "done one cycle", done, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!ce && !sclk && !oe, "R1", "idle pins {ce,sclk,oe}", {ce, sclk, oe}, 0);
        chk(!busy && !done, "R1", "idle busy/done", {busy, done}, 0);

        do_op(1'b1, 5'd3,  8'hA5, 1'b0);   // R3 R4 R5
        do_op(1'b0, 5'd3,  8'h00, 1'b0);   // R6
        do_op(1'b0, 5'd0,  8'h00, 1'b0);
        do_op(1'b1, 5'd31, 8'h5A, 1'b0);
        do_op(1'b0, 5'd31, 8'h00, 1'b0);
        do_op(1'b1, 5'd0,  8'hFF, 1'b0);
        do_op(1'b0, 5'd0,  8'h00, 1'b0);
        do_op(1'b1, 5'd0,  8'h00, 1'b0);
        do_op(1'b0, 5'd0,  8'h00, 1'b0);
        do_op(1'b0, 5'd31, 8'h00, 1'b1);   // R8 start while busy ignored

        repeat (60) @(negedge clk);
        chk(rd_data == exp_mem[31], "R8", "read data held", rd_data, exp_mem[31]);
        chk(!busy && !ce, "R8", "no activity after ignored start", {busy, ce}, 0);
        chk(min_half >= DIV, "R7", "minimum clock half-period", min_half, DIV);

        // R9 read-only variant
        ro_start = 1'b1; ro_write = 1'b1; ro_index = 5'd5;
        @(negedge clk);
        ro_start = 1'b0;
        chk(ro_done && !ro_busy, "R9", "blocked write completes", {ro_done, ro_busy}, 2);
        repeat (50) @(negedge clk);
        chk(ro_ce_rises == 0, "R9", "blocked write bus activity", ro_ce_rises, 0);
        ro_start = 1'b1; ro_write = 1'b1; ro_index = 5'd8;
        @(negedge clk);
        ro_start = 1'b0;
        chk(ro_busy, "R9", "trickle write accepted", ro_busy, 1);
        for (int n = 0; n < 5000 && !ro_done; n++) @(negedge clk);
        chk(ro_ce_rises == 3, "R9", "trickle write transactions", ro_ce_rises, 3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule